// File: doc/BRIEF.md
# Leading-One Position Unit

This execution slice takes a register source operand and reports the position of its highest bit that is 1, counted upward from bit 0. The operand width is picked per operation at run time: 16, 32 or 64 bits. Only the low part of the source that belongs to the selected width is examined. When that part holds at least one 1, the unit writes the position into the destination and clears the zero flag. When it is all zeros, the unit passes the incoming destination value through untouched and raises the zero flag.

The unit accepts one operation per cycle on a valid strobe. The result and the flag appear one clock later, together with a one-cycle result strobe. The other arithmetic flags carry no defined value after this operation. A constant mask output tells downstream flag logic that only the zero flag is meaningful. The source is searched as a set of 16-bit lanes; the operand width enables one, two or all four of them.

Top module: `msb_scan_unit`

## Requirements
- R1: `resValid` is 1 in the cycle after each clock edge at which `inValid` was 1, and 0 after every edge at which `inValid` was 0, so one accepted operation gives a one-cycle pulse.
- R2: When the searched part of the source holds a 1, `zeroFlag` is 0 and the index field holds the unsigned position of the highest 1, with bit 0 as position 0.
- R3: When the searched part of the source is all zeros, `zeroFlag` is 1 and `resValue` equals the `dstOperand` that was presented, bit for bit, in every width mode.
- R4: `opSize` 2'b00 searches source bits 15:0, 2'b01 searches bits 31:0, and 2'b10 or 2'b11 searches bits 63:0; source bits above the selected width have no effect on the result.
- R5: In 16-bit mode with a 1 found, `resValue[63:16]` equals `dstOperand[63:16]` and `resValue[15:0]` is the index with zeros above it.
- R6: In 32-bit mode with a 1 found, `resValue` is the index with zeros in all bits above it up to bit 63.
- R7: In 64-bit mode with a 1 found, `resValue` is the index (0 to 63) with zeros in bits 63:6.
- R8: `flagDefMask` is the constant 6'b001000. Its bit positions are 0 carry, 1 parity, 2 auxiliary carry, 3 zero, 4 sign, 5 overflow.
- R9: While `rst_n` is 0, `resValue`, `zeroFlag` and `resValid` are 0.
- R10: In a cycle with `inValid` 0, `resValue` and `zeroFlag` keep the values they had.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | An operation is presented this cycle |
| srcOperand | input | 64 | Value to search |
| dstOperand | input | 64 | Current destination value, merged or passed through |
| opSize | input | 2 | Width select: 00 = 16, 01 = 32, 10/11 = 64 bits |
| resValid | output | 1 | Result strobe, one cycle after `inValid` |
| resValue | output | 64 | Registered destination result |
| zeroFlag | output | 1 | 1 when the searched part of the source was zero |
| flagDefMask | output | 6 | Marks which flags hold a defined value |

## Verification
The embedded assertions check on every cycle that the result strobe follows the input strobe, and that a zero search returns the destination with the flag set. They also check that a hit leaves the indexed bit as the highest 1 of the searched source, that the upper destination bits are merged or cleared according to the width, and that the result holds while no operation is presented. Only the bench scenarios can show the full value against an independent top-down scan. These scenarios are: one set bit at every position in every width mode, including bits above the width that must be ignored; all-ones and all-zeros sources; random operands in back-to-back and gapped streams; and the values present during and after a reset.

// File: rtl/msb_scan_pkg.sv
package msb_scan_pkg;

  localparam int DATA_W     = 64;
  localparam int LANE_W     = 16;
  localparam int SHORT_W    = 16;
  localparam int MID_W      = 32;
  localparam int NUM_LANES  = DATA_W / LANE_W;
  localparam int IDX_W      = $clog2(DATA_W);
  localparam int LANE_IDX_W = $clog2(LANE_W);
  localparam int LANE_SEL_W = $clog2(NUM_LANES);
  localparam int SHORT_LANES = SHORT_W / LANE_W;
  localparam int MID_LANES   = MID_W / LANE_W;

  localparam logic [NUM_LANES-1:0] SHORT_LANE_MASK = NUM_LANES'((1 << SHORT_LANES) - 1);
  localparam logic [NUM_LANES-1:0] MID_LANE_MASK   = NUM_LANES'((1 << MID_LANES) - 1);
  localparam logic [NUM_LANES-1:0] FULL_LANE_MASK  = '1;

  // Flag vector layout
  localparam int FLAG_W       = 6;
  localparam int FLAG_CARRY   = 0;
  localparam int FLAG_PARITY  = 1;
  localparam int FLAG_AUX     = 2;
  localparam int FLAG_ZERO    = 3;
  localparam int FLAG_SIGN    = 4;
  localparam int FLAG_OVER    = 5;
  localparam logic [FLAG_W-1:0] FLAG_DEF_MASK = FLAG_W'(1 << FLAG_ZERO);

  typedef enum logic [1:0] {
    SIZE_16     = 2'b00,
    SIZE_32     = 2'b01,
    SIZE_64     = 2'b10,
    SIZE_64_ALT = 2'b11
  } op_size_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic                 capture;
    logic [NUM_LANES-1:0] laneEn;
    logic                 keepUpper;
  } scan_ctrl_t;

endpackage

// File: rtl/msb_lane_enc.sv
module msb_lane_enc #(
  parameter int W     = 16,
  localparam int POS_W = $clog2(W)
) (
  input  logic [W-1:0]     laneBits,
  output logic [POS_W-1:0] lanePos,
  output logic             laneHit
);

  // Ascending walk: the highest set bit is the last one assigned
  always_comb begin
    lanePos = '0;
    for (int i = 0; i < W; i++) begin
      if (laneBits[i]) lanePos = POS_W'(i);
    end
  end

  assign laneHit = |laneBits;

endmodule

// File: rtl/msb_scan_ctrl.sv
module msb_scan_ctrl
  import msb_scan_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       inValid,
  input  logic [1:0] opSize,
  output scan_ctrl_t ctrlStrb,
  output logic       resValid
);

  op_size_e sizeSel;
  assign sizeSel = op_size_e'(opSize);

  always_comb begin
    ctrlStrb.capture   = inValid;
    ctrlStrb.keepUpper = (sizeSel == SIZE_16);
    case (sizeSel)
      SIZE_16: ctrlStrb.laneEn = SHORT_LANE_MASK;
      SIZE_32: ctrlStrb.laneEn = MID_LANE_MASK;
      default: ctrlStrb.laneEn = FULL_LANE_MASK;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) resValid <= 1'b0;
    else        resValid <= inValid;
  end

  // R1: strobe follows the accepted operation by one cycle
  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    inValid |=> resValid);
  a_r1_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
    !inValid |=> !resValid);

  // R4: lane 0 is always searched, the wide encodings open every lane
  a_r4_low_lane: assert property (@(posedge clk) disable iff (!rst_n)
    ctrlStrb.capture |-> ctrlStrb.laneEn[0]);
  a_r4_wide_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    (opSize[1] == 1'b1) |-> (&ctrlStrb.laneEn && !ctrlStrb.keepUpper));

endmodule

// File: rtl/msb_scan_datapath.sv
module msb_scan_datapath
  import msb_scan_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  scan_ctrl_t        ctrlStrb,
  input  logic [DATA_W-1:0] srcOperand,
  input  logic [DATA_W-1:0] dstOperand,
  output logic [DATA_W-1:0] resValue,
  output logic              zeroFlag
);

  logic [DATA_W-1:0]     searchedBits;
  logic [LANE_IDX_W-1:0] lanePos [NUM_LANES];
  logic [NUM_LANES-1:0]  laneHit;

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    assign searchedBits[l*LANE_W +: LANE_W] =
      srcOperand[l*LANE_W +: LANE_W] & {LANE_W{ctrlStrb.laneEn[l]}};
    msb_lane_enc #(.W(LANE_W)) i_enc (
      .laneBits (searchedBits[l*LANE_W +: LANE_W]),
      .lanePos  (lanePos[l]),
      .laneHit  (laneHit[l])
    );
  end

  logic [LANE_SEL_W-1:0] topLane;
  logic                  anyHit;
  logic [IDX_W-1:0]      scanIdx;
  logic [DATA_W-1:0]     nextValue;

  always_comb begin
    topLane = '0;
    for (int l = 0; l < NUM_LANES; l++) begin
      if (laneHit[l]) topLane = LANE_SEL_W'(l);
    end
  end

  assign anyHit  = |laneHit;
  assign scanIdx = {topLane, lanePos[topLane]};

  always_comb begin
    if (!anyHit)
      nextValue = dstOperand;
    else if (ctrlStrb.keepUpper)
      nextValue = {dstOperand[DATA_W-1:SHORT_W], SHORT_W'(scanIdx)};
    else
      nextValue = DATA_W'(scanIdx);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resValue <= '0;
      zeroFlag <= 1'b0;
    end else if (ctrlStrb.capture) begin
      resValue <= nextValue;
      zeroFlag <= !anyHit;
    end
  end

  // R3: empty search returns the destination with the flag raised
  a_r3_zero_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrlStrb.capture && searchedBits == '0) |=>
      (zeroFlag && resValue == $past(dstOperand)));

  // R2: the reported bit is set and nothing above it is
  a_r2_top_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrlStrb.capture && searchedBits != '0) |=>
      (!zeroFlag && (($past(searchedBits) >> resValue[IDX_W-1:0]) == DATA_W'(1))));

  // R5: short mode merges into the upper destination bits
  a_r5_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrlStrb.capture && ctrlStrb.keepUpper && searchedBits != '0) |=>
      (resValue[DATA_W-1:SHORT_W] == $past(dstOperand[DATA_W-1:SHORT_W]) &&
       resValue[SHORT_W-1:IDX_W] == '0));

  // R6, R7: wider modes zero-extend the index
  a_r6_zero_extend: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrlStrb.capture && !ctrlStrb.keepUpper && searchedBits != '0) |=>
      (resValue[DATA_W-1:IDX_W] == '0));

  // R10: no operation, no change
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrlStrb.capture |=> ($stable(resValue) && $stable(zeroFlag)));

endmodule

// File: rtl/msb_scan_unit.sv
module msb_scan_unit
  import msb_scan_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inValid,
  input  logic [DATA_W-1:0] srcOperand,
  input  logic [DATA_W-1:0] dstOperand,
  input  logic [1:0]        opSize,
  output logic              resValid,
  output logic [DATA_W-1:0] resValue,
  output logic              zeroFlag,
  output logic [FLAG_W-1:0] flagDefMask
);

  scan_ctrl_t ctrlStrb;

  msb_scan_ctrl i_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .inValid  (inValid),
    .opSize   (opSize),
    .ctrlStrb (ctrlStrb),
    .resValid (resValid)
  );

  msb_scan_datapath i_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrlStrb   (ctrlStrb),
    .srcOperand (srcOperand),
    .dstOperand (dstOperand),
    .resValue   (resValue),
    .zeroFlag   (zeroFlag)
  );

  // R8: only the zero flag carries a defined value
  assign flagDefMask = FLAG_DEF_MASK;

  // R9: cleared state right after a reset edge
  a_r9_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (!resValid && resValue == '0 && !zeroFlag));

endmodule

// File: tb/test_msb_scan_unit.sv
`timescale 1ns/1ps
module test_msb_scan_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        inValid = 1'b0;
  logic [63:0] srcOperand = '0;
  logic [63:0] dstOperand = '0;
  logic [1:0]  opSize = 2'b00;
  logic        resValid;
  logic [63:0] resValue;
  logic        zeroFlag;
  logic [5:0]  flagDefMask;

  msb_scan_unit i_msb_scan_unit (
    .clk(clk), .rst_n(rst_n), .inValid(inValid),
    .srcOperand(srcOperand), .dstOperand(dstOperand), .opSize(opSize),
    .resValid(resValid), .resValue(resValue), .zeroFlag(zeroFlag),
    .flagDefMask(flagDefMask)
  );

  always #2 clk = ~clk;

  typedef struct {
    logic [63:0] val;
    logic        zf;
    string       tag;
  } exp_t;

  exp_t        expQ[$];
  int          checks = 0;
  int          errors = 0;
  bit          done = 0;
  logic [63:0] lastVal = '0;
  logic        lastZf = 1'b0;

  task automatic checkVal(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Independent model: scan from the top of the selected width down
  function automatic exp_t refModel(logic [63:0] src, logic [63:0] dst,
                                    logic [1:0] sz, string tag);
    exp_t e;
    int   w;
    int   pos;
    w   = (sz == 2'b00) ? 16 : (sz == 2'b01) ? 32 : 64;
    pos = -1;
    for (int i = w - 1; i >= 0; i--) begin
      if (pos < 0 && src[i]) pos = i;
    end
    e.tag = tag;
    if (pos < 0) begin
      e.val = dst;
      e.zf  = 1'b1;
    end else begin
      e.zf = 1'b0;
      if (sz == 2'b00) e.val = {dst[63:16], 16'(pos)};
      else             e.val = 64'(pos);
    end
    return e;
  endfunction

  task automatic sendOp(logic [63:0] src, logic [63:0] dst, logic [1:0] sz, string tag);
    @(negedge clk);
    inValid    = 1'b1;
    srcOperand = src;
    dstOperand = dst;
    opSize     = sz;
    expQ.push_back(refModel(src, dst, sz, tag));
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      inValid    = 1'b0;
      srcOperand = {$urandom, $urandom};
      dstOperand = {$urandom, $urandom};
    end
  endtask

  // Monitor: pop and compare every result strobe
  always @(negedge clk) begin
    if (rst_n && resValid) begin
      if (expQ.size() == 0) begin
        checks++;
        errors++;
        $display("FAIL R1 actual=resValid 1 expected=resValid 0");
      end else begin
        exp_t e;
        e = expQ.pop_front();
        checkVal(e.tag, resValue, e.val);
        checkVal(e.tag, 64'(zeroFlag), 64'(e.zf));
        lastVal = e.val;
        lastZf  = e.zf;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R9: reset state
    repeat (3) @(negedge clk);
    checkVal("R9", resValue, 64'h0);
    checkVal("R9", 64'(zeroFlag), 64'h0);
    checkVal("R9", 64'(resValid), 64'h0);
    // R8: defined-flag mask, zero flag at bit 3
    checkVal("R8", 64'(flagDefMask), 64'h08);
    rst_n = 1'b1;
    idle(2);

    // R1: one-cycle pulse timing
    sendOp(64'h0000_0000_0000_0100, 64'hFFFF_FFFF_FFFF_FFFF, 2'b10, "R7");
    idle(1);
    checkVal("R1", 64'(resValid), 64'h1);
    @(negedge clk);
    checkVal("R1", 64'(resValid), 64'h0);

    // Single set bit at every position in every size encoding (R2, R4)
    for (int sz = 0; sz < 4; sz++) begin
      for (int p = 0; p < 64; p++) begin
        int w;
        w = (sz == 0) ? 16 : (sz == 1) ? 32 : 64;
        sendOp(64'h1 << p, {$urandom, $urandom}, 2'(sz), (p >= w) ? "R4" : "R2");
      end
      idle(1);
    end

    // All ones, all zeros per size (R5, R6, R7, R3)
    for (int sz = 0; sz < 4; sz++) begin
      sendOp('1, 64'hA5A5_5A5A_C3C3_3C3C, 2'(sz),
             (sz == 0) ? "R5" : (sz == 1) ? "R6" : "R7");
      sendOp('0, {$urandom, $urandom}, 2'(sz), "R3");
    end
    // Upper bits only, lower searched part zero (R3, R4)
    sendOp(64'hFFFF_FFFF_FFFF_0000, 64'h1234_5678_9ABC_DEF0, 2'b00, "R3");
    sendOp(64'hFFFF_FFFF_0000_0000, 64'h0FED_CBA9_8765_4321, 2'b01, "R3");
    idle(2);

    // R10: hold while idle
    idle(3);
    checkVal("R10", resValue, lastVal);
    checkVal("R10", 64'(zeroFlag), 64'(lastZf));

    // Random streams, back-to-back and gapped, each size
    for (int sz = 0; sz < 4; sz++) begin
      for (int n = 0; n < 40; n++) begin
        logic [63:0] s;
        s = {$urandom, $urandom} >> ($urandom % 64);
        sendOp(s, {$urandom, $urandom}, 2'(sz),
               (sz == 0) ? "R5" : (sz == 1) ? "R6" : "R7");
        if ($urandom % 3 == 0) idle(1 + $urandom % 2);
      end
    end
    idle(3);
    checkVal("R10", resValue, lastVal);

    // R9: reset after activity clears everything
    sendOp(64'h8000_0000_0000_0000, '0, 2'b10, "R7");
    idle(2);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    checkVal("R9", resValue, 64'h0);
    checkVal("R9", 64'(zeroFlag), 64'h0);
    checkVal("R9", 64'(resValid), 64'h0);
    rst_n = 1'b1;
    idle(2);

    checkVal("R1", 64'(expQ.size()), 64'h0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule